// File: doc/BRIEF.md
# Gated Inactivity Power-Off Timer

This block shuts the system down when software stops servicing it. A period counter advances on a slow tick enable and restarts on the external master reset, or when software writes the service strobe and the write is allowed. Two external status levels decide whether a write is allowed: the filtered receive-carrier level and the transmit-power level. Software gets no indication of whether a write was taken. No other reset input exists, so a watchdog reset elsewhere in the system cannot clear this timer.

When the period expires, the block raises a level timeout interrupt. This gives software a warning period before power is removed. After a fixed further number of ticks it drives the active-low power-off output low. Once this sequence starts it cannot be stopped. Service writes are ignored from then on, and both outputs hold until the master reset. With a 492 Hz tick, the defaults give a 30 s period and a 1 s warning.

Top module: `inact_pwroff_timer`

## Requirements
- R1: In the cycle after `mrst` is high, `tmo_irq` is 0 and `pwr_off_n` is 1. The period count also restarts from zero.
- R2: `tmo_irq` becomes 1 in the cycle after the clock edge that samples the PERIOD_TICKS-th `tick_en` pulse since the last restart.
- R3: Cycles with `tick_en` low do not advance either the period count or the warning count.
- R4: A `svc_wr` pulse is accepted when `carrier_ok`=1 or `tx_pwr`=0. An accepted pulse restarts the period count, and it beats a tick in the same cycle, so that cycle does not count.
- R5: A `svc_wr` pulse with `carrier_ok`=0 and `tx_pwr`=1 is refused and leaves the period count unchanged.
- R6: `pwr_off_n` falls in the cycle after the edge that samples the GAP_TICKS-th tick counted after `tmo_irq` rose. Until then it stays at 1.
- R7: While `tmo_irq` is 1, `svc_wr` has no effect, whatever the levels of `carrier_ok` and `tx_pwr`.
- R8: Once set, `tmo_irq`=1 and `pwr_off_n`=0 hold until `mrst`.
- R9: `mrst` ends a running warning period and takes priority over ticks and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mrst | input | 1 | External master reset, synchronous, active high |
| tick_en | input | 1 | Slow time-base enable, one cycle per tick |
| svc_wr | input | 1 | Software write strobe to the service register |
| carrier_ok | input | 1 | Filtered receive-carrier level |
| tx_pwr | input | 1 | Transmit-power level |
| tmo_irq | output | 1 | Timeout interrupt, level, registered |
| pwr_off_n | output | 1 | Power-off request, active low, registered |

## Verification
The bench builds the block with PERIOD_TICKS=40 and GAP_TICKS=6. This makes a full timeout, the whole warning period and the power-off reachable within a few hundred cycles, so many complete sequences fit into one run. At these sizes the bench can approach the exact last tick of both counts on purpose. This covers a write in the same cycle as the final tick, all four gate combinations just before expiry, and a master reset inside the warning period. Random phases vary the tick density and the write rate so that both expiry and steady servicing occur.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_WARN = 2'd1,
    PH_OFF  = 2'd2
  } phase_e;
endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int LIMIT = 492
) (
  input  logic clk,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign hit = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (clr)
      cnt <= '0;
    else if (en)
      cnt <= hit ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/svc_gate.sv
module svc_gate (
  input  logic svc_wr,
  input  logic carrier_ok,
  input  logic tx_pwr,
  input  logic armed,
  output logic restart
);
  // Refused only for carrier low together with transmit power high.
  assign restart = armed && svc_wr && (carrier_ok || !tx_pwr);
endmodule

// File: rtl/off_sequencer.sv
module off_sequencer
  import tmr_pkg::*;
(
  input  logic   clk,
  input  logic   mrst,
  input  logic   period_hit,
  input  logic   restart,
  input  logic   gap_hit,
  output phase_e phase,
  output logic   tmo_irq,
  output logic   pwr_off_n
);
  always_ff @(posedge clk) begin
    if (mrst) begin
      phase     <= PH_RUN;
      tmo_irq   <= 1'b0;
      pwr_off_n <= 1'b1;
    end else begin
      unique case (phase)
        PH_RUN: if (period_hit && !restart) begin
          phase   <= PH_WARN;
          tmo_irq <= 1'b1;
        end
        PH_WARN: if (gap_hit) begin
          phase     <= PH_OFF;
          pwr_off_n <= 1'b0;
        end
        default: phase <= PH_OFF;
      endcase
    end
  end
endmodule

// File: rtl/inact_pwroff_timer.sv
module inact_pwroff_timer
  import tmr_pkg::*;
#(
  parameter int PERIOD_TICKS = 14760,
  parameter int GAP_TICKS    = 492
) (
  input  logic clk,
  input  logic mrst,
  input  logic tick_en,
  input  logic svc_wr,
  input  logic carrier_ok,
  input  logic tx_pwr,
  output logic tmo_irq,
  output logic pwr_off_n
);
  phase_e phase;
  logic   restart, period_hit, gap_hit, running, warning;

  assign running = (phase == PH_RUN);
  assign warning = (phase == PH_WARN);

  svc_gate u_gate (
    .svc_wr     (svc_wr),
    .carrier_ok (carrier_ok),
    .tx_pwr     (tx_pwr),
    .armed      (running),
    .restart    (restart)
  );

  tick_counter #(.LIMIT(PERIOD_TICKS)) u_period (
    .clk (clk),
    .clr (mrst || restart || !running),
    .en  (tick_en && running),
    .hit (period_hit)
  );

  tick_counter #(.LIMIT(GAP_TICKS)) u_gap (
    .clk (clk),
    .clr (mrst || !warning),
    .en  (tick_en && warning),
    .hit (gap_hit)
  );

  off_sequencer u_seq (
    .clk        (clk),
    .mrst       (mrst),
    .period_hit (period_hit),
    .restart    (restart),
    .gap_hit    (gap_hit),
    .phase      (phase),
    .tmo_irq    (tmo_irq),
    .pwr_off_n  (pwr_off_n)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int GAP_TICKS = 492
) (
  input logic clk,
  input logic mrst,
  input logic tick_en,
  input logic tmo_irq,
  input logic pwr_off_n
);
  localparam int GW = $clog2(GAP_TICKS + 1) + 1;
  logic [GW-1:0] warn_ticks;

  always_ff @(posedge clk) begin
    if (mrst)
      warn_ticks <= '0;
    else if (tick_en && tmo_irq && pwr_off_n)
      warn_ticks <= warn_ticks + 1'b1;
  end

  p_reset_state_r1: assert property (@(posedge clk) mrst |=> (!tmo_irq && pwr_off_n));
  p_irq_on_tick_r2: assert property (@(posedge clk) disable iff (mrst) $rose(tmo_irq) |-> $past(tick_en));
  p_off_after_gap_r6: assert property (@(posedge clk) disable iff (mrst)
    $fell(pwr_off_n) |-> (tmo_irq && warn_ticks == GW'(GAP_TICKS)));
  p_no_off_without_irq_r6: assert property (@(posedge clk) disable iff (mrst) !pwr_off_n |-> tmo_irq);
  p_irq_holds_r8: assert property (@(posedge clk) (tmo_irq && !mrst) |=> tmo_irq);
  p_off_holds_r8: assert property (@(posedge clk) (!pwr_off_n && !mrst) |=> !pwr_off_n);
endmodule

bind inact_pwroff_timer tmr_chk #(.GAP_TICKS(GAP_TICKS)) u_chk (
  .clk       (clk),
  .mrst      (mrst),
  .tick_en   (tick_en),
  .tmo_irq   (tmo_irq),
  .pwr_off_n (pwr_off_n)
);

// File: tb/tb_inact_pwroff_timer.sv
module tb_inact_pwroff_timer;
  localparam int PER = 40;
  localparam int GAP = 6;

  logic clk = 1'b0;
  logic mrst = 1'b1, tick_en = 1'b0, svc_wr = 1'b0, carrier_ok = 1'b0, tx_pwr = 1'b0;
  logic tmo_irq, pwr_off_n;

  int n_chk = 0, n_fail = 0;
  int m_cnt = 0, m_gap = 0, m_ph = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  inact_pwroff_timer #(.PERIOD_TICKS(PER), .GAP_TICKS(GAP)) dut (
    .clk(clk), .mrst(mrst), .tick_en(tick_en), .svc_wr(svc_wr),
    .carrier_ok(carrier_ok), .tx_pwr(tx_pwr), .tmo_irq(tmo_irq), .pwr_off_n(pwr_off_n)
  );

  function automatic bit exp_irq();  return m_ph != 0; endfunction
  function automatic bit exp_pon();  return m_ph != 2; endfunction
  function automatic bit accepted(bit c, bit t); return c || !t; endfunction

  task automatic chk(string tag, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model(bit mr, bit tk, bit wr, bit c, bit t);
    if (mr) begin m_cnt = 0; m_gap = 0; m_ph = 0; end
    else if (m_ph == 0) begin
      if (wr && accepted(c, t)) m_cnt = 0;
      else if (tk) begin
        if (m_cnt == PER - 1) begin m_ph = 1; m_gap = 0; m_cnt = 0; end
        else m_cnt++;
      end
    end else if (m_ph == 1 && tk) begin
      if (m_gap == GAP - 1) m_ph = 2;
      else m_gap++;
    end
  endtask

  task automatic step(bit mr, bit tk, bit wr, bit c, bit t);
    mrst = mr; tick_en = tk; svc_wr = wr; carrier_ok = c; tx_pwr = t;
    model(mr, tk, wr, c, t);
    @(negedge clk);
    chk("R2 irq vs model", tmo_irq, exp_irq());
    chk("R6 pwr_off_n vs model", pwr_off_n, exp_pon());
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(0, 1, 0, 0, 0);
  endtask

  task automatic reset_dut();
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(1, 1, 1, 1, 0);
    step(1, 0, 0, 0, 0);
    chk("R1 reset irq", tmo_irq, 1'b0);
    chk("R1 reset pwr_off_n", pwr_off_n, 1'b1);
    step(0, 0, 0, 0, 0);

    // R3: no ticks, nothing advances
    for (int i = 0; i < 200; i++) step(0, 0, 0, 0, 0);
    chk("R3 idle no irq", tmo_irq, 1'b0);

    // R2 exact period, R6 exact gap, R7 writes ignored, R8 hold
    ticks(PER - 1);
    chk("R2 before last tick", tmo_irq, 1'b0);
    step(0, 1, 0, 0, 0);
    chk("R2 irq at last tick", tmo_irq, 1'b1);
    for (int i = 0; i < GAP - 1; i++) begin
      step(0, 1, 1, 1, 0);
      chk("R7 write ignored, pwr still on", pwr_off_n, 1'b1);
    end
    step(0, 1, 1, 1, 1);
    chk("R6 pwr_off_n low", pwr_off_n, 1'b0);
    for (int i = 0; i < 50; i++) step(0, i % 2, 1, 1, 0);
    chk("R8 irq holds", tmo_irq, 1'b1);
    chk("R8 pwr_off_n holds", pwr_off_n, 1'b0);
    reset_dut();
    chk("R1 after off", pwr_off_n, 1'b1);

    // R5 refused write
    ticks(PER - 1);
    step(0, 0, 1, 0, 1);
    step(0, 1, 0, 0, 0);
    chk("R5 refused write no restart", tmo_irq, 1'b1);
    reset_dut();

    // R4 the three accepted combinations
    for (int k = 0; k < 3; k++) begin
      bit c = (k != 0);
      bit t = (k == 2);
      ticks(PER - 1);
      step(0, 0, 1, c, t);
      ticks(PER - 1);
      chk("R4 accepted write restarted", tmo_irq, 1'b0);
      step(0, 1, 0, 0, 0);
      chk("R4 full period after restart", tmo_irq, 1'b1);
      reset_dut();
    end

    // R4 write beats a same-cycle last tick
    ticks(PER - 1);
    step(0, 1, 1, 0, 0);
    chk("R4 write beats last tick", tmo_irq, 1'b0);
    reset_dut();

    // R9 reset inside warning period, with tick and write
    ticks(PER);
    ticks(GAP - 2);
    step(1, 1, 1, 1, 0);
    chk("R9 reset ends warning irq", tmo_irq, 1'b0);
    chk("R9 reset ends warning pwr", pwr_off_n, 1'b1);
    ticks(GAP + 3);
    chk("R9 no late power-off", pwr_off_n, 1'b1);
    reset_dut();

    // Random phases
    void'($urandom(32'h5EED_0042));
    for (int seg = 0; seg < 40; seg++) begin
      int tk_pct = 20 + ($urandom % 80);
      int wr_div = 20 + ($urandom % 200);
      for (int i = 0; i < 300; i++) begin
        bit mr = ($urandom % 600) == 0;
        bit tk = ($urandom % 100) < tk_pct;
        bit wr = ($urandom % wr_div) == 0;
        step(mr, tk, wr, 1'($urandom), 1'($urandom));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule